// File: doc/BRIEF.md
# Complement-Keyed Watchdog Timer

The block is a watchdog that software keeps alive by writing an 8-bit service key. The first key written after reset or after a watchdog reset arms the timer and starts its counter from zero. From then on, writing the bitwise inverse of the stored key restarts the count and makes the written value the new stored key. Valid services therefore alternate between a value and its complement. Writing the stored key again changes nothing. Writing any other value trips the watchdog at once.

The counter advances only on cycles where the tick input is high. A 2-bit select chooses one of four timeout lengths. The watchdog also trips when the clock source that drives it is switched off while the timer is armed. Each trip produces a one-cycle reset request together with a cause code. The block then falls back to the idle, unarmed state.

Top module: `key_watchdog`

## Requirements
- R1: While rst_ni is low and after its release, with no key written, wdt_rst_o is 0 and rst_cause_o is 00.
- R2: A key write while idle stores the written byte, arms the timer and sets its count to zero. A tick in that same cycle is not counted.
- R3: While armed, writing a byte equal to the stored key has no effect. The count keeps running and the stored key is unchanged.
- R4: While armed, writing the bitwise inverse of the stored key clears the count to zero and stores the written byte. The next valid service is the inverse of that byte.
- R5: While armed, writing a byte equal to neither the stored key nor its inverse gives wdt_rst_o = 1 with rst_cause_o = 10 in the cycle after the write.
- R6: Once armed, the count reaching 2^(10+2*intv_sel_i) ticks without a service gives wdt_rst_o = 1 with rst_cause_o = 01 in the cycle after the last tick. The values 0, 1, 2 and 3 select 1024, 4096, 16384 and 65536 ticks.
- R7: The count advances only on cycles where tick_i is 1.
- R8: While armed, clk_src_en_i = 0 gives wdt_rst_o = 1 with rst_cause_o = 11 in the next cycle.
- R9: While idle, clk_src_en_i = 0, tick_i and elapsed time never raise wdt_rst_o.
- R10: wdt_rst_o is high for exactly one cycle, and rst_cause_o is 00 whenever wdt_rst_o is 0. After the pulse the block is idle, so the next write arms it afresh.
- R11: A valid inverse write in the same cycle as the terminal tick clears the count, and no overflow is reported.
- R12: When several trip conditions occur in one cycle, the reported cause follows the priority illegal key (10), then clock disabled (11), then overflow (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Key register write strobe |
| wr_data_i | input | 8 | Key write data |
| intv_sel_i | input | 2 | Timeout interval select |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| clk_src_en_i | input | 1 | Enable of the watchdog's clock source |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |
| rst_cause_o | output | 2 | Trip cause: 01 overflow, 10 illegal key, 11 clock disabled |

## Verification
Two events can land in the same cycle: a key write and the tick that completes the interval. The bench arms the timer, feeds exactly one tick fewer than the terminal count, and then issues the write together with the final tick. An inverse write must produce no pulse, after which a full fresh interval must pass before the next overflow. An illegal write must report cause 10 rather than 01. The random phase produces further overlaps of writes, ticks and clock-disable events, and every cycle is compared with a bench model written from the requirements.

// File: rtl/kw_pkg.sv
package kw_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OVF  = 2'b01,
    CAUSE_KEY  = 2'b10,
    CAUSE_CLK  = 2'b11
  } cause_e;
endpackage

// File: rtl/kw_key_unit.sv
module kw_key_unit #(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] data_i,
  output logic [KEY_W-1:0] key_o,
  output logic             same_o,
  output logic             inv_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     key_q <= '0;
    else if (load_i) key_q <= data_i;
  end

  assign key_o  = key_q;
  assign same_o = (data_i == key_q);
  assign inv_o  = (data_i == ~key_q);
endmodule

// File: rtl/kw_tick_counter.sv
module kw_tick_counter #(
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             term_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt [NSEL];

  // last count value before the terminal tick, one per interval select
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign last_cnt[g] = CNT_W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * g)) - 64'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign term_o = run_i && tick_i && (cnt_q == last_cnt[sel_i]);
endmodule

// File: rtl/kw_fault_gen.sv
module kw_fault_gen
  import kw_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   arm_i,
  input  logic   bad_key_i,
  input  logic   clk_off_i,
  input  logic   ovf_i,
  output logic   armed_o,
  output logic   fault_o,
  output logic   rst_o,
  output cause_e cause_o
);
  logic   armed_q, rst_q;
  cause_e cause_q, cause_d;

  assign fault_o = armed_q && (bad_key_i || clk_off_i || ovf_i);

  always_comb begin
    if (bad_key_i)      cause_d = CAUSE_KEY;
    else if (clk_off_i) cause_d = CAUSE_CLK;
    else                cause_d = CAUSE_OVF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      rst_q   <= fault_o;
      cause_q <= fault_o ? cause_d : CAUSE_NONE;
      if (fault_o)    armed_q <= 1'b0;
      else if (arm_i) armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
  assign rst_o   = rst_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kw_pkg::*;
#(
  parameter int KEY_W     = 8,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 10,
  parameter int STEP_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] intv_sel_i,
  input  logic             tick_i,
  input  logic             clk_src_en_i,
  output logic             wdt_rst_o,
  output logic [1:0]       rst_cause_o
);
  logic             armed_q, fault;
  logic [KEY_W-1:0] key_q;
  logic             key_same, key_inv, term_hit;
  logic             arm_req, svc_ok, bad_key, clk_off, ovf;
  cause_e           cause;

  assign arm_req = wr_en_i && !armed_q;
  assign svc_ok  = wr_en_i && armed_q && key_inv;
  assign bad_key = wr_en_i && armed_q && !key_same && !key_inv;
  assign clk_off = armed_q && !clk_src_en_i;
  assign ovf     = term_hit && !svc_ok;  // service on the last tick wins

  kw_key_unit #(.KEY_W(KEY_W)) key_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (arm_req || svc_ok),
    .data_i (wr_data_i),
    .key_o  (key_q),
    .same_o (key_same),
    .inv_o  (key_inv)
  );

  kw_tick_counter #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .SEL_W     (SEL_W)
  ) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (armed_q),
    .clr_i  (!armed_q || svc_ok || fault),
    .tick_i (tick_i),
    .sel_i  (intv_sel_i),
    .term_o (term_hit)
  );

  kw_fault_gen flt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_req),
    .bad_key_i (bad_key),
    .clk_off_i (clk_off),
    .ovf_i     (ovf),
    .armed_o   (armed_q),
    .fault_o   (fault),
    .rst_o     (wdt_rst_o),
    .cause_o   (cause)
  );

  assign rst_cause_o = cause;
endmodule

// File: rtl/kw_checker.sv
module kw_checker #(
  parameter int KEY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [KEY_W-1:0] wr_data_i,
  input logic             clk_src_en_i,
  input logic             armed_i,
  input logic [KEY_W-1:0] key_i,
  input logic             wdt_rst_o,
  input logic [1:0]       rst_cause_o
);
  logic illegal_wr;
  assign illegal_wr = armed_i && wr_en_i && (wr_data_i != key_i) && (wr_data_i != ~key_i);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);  // R10
  AST_CAUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_rst_o |-> rst_cause_o == 2'b00);  // R10
  AST_PULSE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !armed_i);  // R10
  AST_IDLE_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !wdt_rst_o);  // R9
  AST_ILLEGAL_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_wr |=> wdt_rst_o && rst_cause_o == 2'b10);  // R5
  AST_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && !clk_src_en_i && !illegal_wr |=> wdt_rst_o && rst_cause_o == 2'b11);  // R8
  AST_SAME_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && wr_en_i && wr_data_i == key_i |=> $stable(key_i));  // R3
  AST_SVC_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && wr_en_i && wr_data_i == ~key_i |=> key_i == $past(wr_data_i));  // R4
  AST_ARM_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i && wr_en_i |=> armed_i && key_i == $past(wr_data_i));  // R2
endmodule

bind key_watchdog kw_checker #(.KEY_W(KEY_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .clk_src_en_i (clk_src_en_i),
  .armed_i      (armed_q),
  .key_i        (key_q),
  .wdt_rst_o    (wdt_rst_o),
  .rst_cause_o  (rst_cause_o)
);

// File: tb/key_watchdog_tb_top.sv
`timescale 1ns/1ps
module key_watchdog_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [1:0] intv_sel_i = 2'd0;
  logic       tick_i = 1'b0;
  logic       clk_src_en_i = 1'b1;
  logic       wdt_rst_o;
  logic [1:0] rst_cause_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit         m_armed = 1'b0;
  logic [7:0] m_key = 8'h00;
  int         m_cnt = 0;
  bit         exp_rst = 1'b0;
  logic [1:0] exp_cause = 2'b00;
  string      exp_tag = "R1";

  key_watchdog dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .intv_sel_i,
    .tick_i, .clk_src_en_i, .wdt_rst_o, .rst_cause_o
  );

  always #4 clk_i = ~clk_i;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rst/cause actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int limit(logic [1:0] sel);
    return 1 << (10 + 2 * sel);
  endfunction

  // compute the outputs expected after the next edge from the requirements
  task automatic model(bit we, logic [7:0] d, logic [1:0] sel, bit tk, bit en);
    bit ill, svc, ovf;
    exp_rst = 1'b0;
    exp_cause = 2'b00;
    if (!m_armed) begin
      if (we) begin
        m_armed = 1'b1; m_key = d; m_cnt = 0;   // R2
      end
    end else begin
      ill = we && d != m_key && d != ~m_key;    // R5
      svc = we && d == ~m_key;                  // R4
      ovf = tk && (m_cnt + 1 == limit(sel)) && !svc;  // R6 R11
      if (ill || !en || ovf) begin              // R12 priority
        exp_rst = 1'b1;
        exp_cause = ill ? 2'b10 : (!en ? 2'b11 : 2'b01);
        m_armed = 1'b0;
        m_cnt = 0;
      end else if (svc) begin
        m_key = d; m_cnt = 0;
      end else if (tk) begin
        m_cnt++;                                // R7
      end
    end
  endtask

  task automatic step(bit we, logic [7:0] d, logic [1:0] sel, bit tk, bit en, string tag);
    @(negedge clk_i);
    check(exp_tag, {wdt_rst_o, rst_cause_o}, {exp_rst, exp_cause});
    wr_en_i = we; wr_data_i = d; intv_sel_i = sel; tick_i = tk; clk_src_en_i = en;
    model(we, d, sel, tk, en);
    exp_tag = tag;
  endtask

  task automatic ticks(int n, logic [1:0] sel, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, sel, 1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #20;
    check("R1", {wdt_rst_o, rst_cause_o}, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R9: idle, clock source off and ticking: no trip
    for (int i = 0; i < 1500; i++) step(1'b0, 8'h00, 2'd0, 1'b1, i[0], "R9");

    // R2 R4 R3: 55 arms, AA clears, AA again ignored, 55 clears
    step(1'b1, 8'h55, 2'd0, 1'b1, 1'b1, "R2");
    ticks(600, 2'd0, "R2");
    step(1'b1, 8'hAA, 2'd0, 1'b1, 1'b1, "R4");
    ticks(300, 2'd0, "R4");
    step(1'b1, 8'hAA, 2'd0, 1'b1, 1'b1, "R3");
    ticks(300, 2'd0, "R3");
    step(1'b1, 8'h55, 2'd0, 1'b1, 1'b1, "R4");
    ticks(1030, 2'd0, "R6");  // overflow inside this run

    // R5: 33 stored, CB illegal
    step(1'b1, 8'h33, 2'd0, 1'b0, 1'b1, "R2");
    step(1'b1, 8'hCC, 2'd0, 1'b0, 1'b1, "R4");
    step(1'b1, 8'h33, 2'd0, 1'b0, 1'b1, "R4");
    step(1'b1, 8'hCB, 2'd0, 1'b0, 1'b1, "R5");
    step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1, "R10");
    step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1, "R10");

    // R7: tick every other cycle
    step(1'b1, 8'h0F, 2'd0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 2060; i++) step(1'b0, 8'h00, 2'd0, i[0], 1'b1, "R7");

    // R8: clock source off while armed
    step(1'b1, 8'h5A, 2'd0, 1'b1, 1'b1, "R2");
    ticks(10, 2'd0, "R8");
    step(1'b0, 8'h00, 2'd0, 1'b1, 1'b0, "R8");
    step(1'b0, 8'h00, 2'd0, 1'b1, 1'b0, "R9");

    // R11: inverse write on the terminal tick, then a full fresh interval
    step(1'b1, 8'h55, 2'd0, 1'b1, 1'b1, "R2");
    ticks(1023, 2'd0, "R11");
    step(1'b1, 8'hAA, 2'd0, 1'b1, 1'b1, "R11");
    ticks(1030, 2'd0, "R11");

    // R12: illegal write on the terminal tick; illegal with clock off
    step(1'b1, 8'h33, 2'd0, 1'b1, 1'b1, "R2");
    ticks(1023, 2'd0, "R12");
    step(1'b1, 8'hCB, 2'd0, 1'b1, 1'b1, "R12");
    step(1'b1, 8'h33, 2'd0, 1'b0, 1'b1, "R2");
    step(1'b1, 8'h00, 2'd0, 1'b0, 1'b0, "R12");
    step(1'b1, 8'h33, 2'd0, 1'b1, 1'b1, "R2");
    ticks(1023, 2'd0, "R12");
    step(1'b0, 8'h00, 2'd0, 1'b1, 1'b0, "R12");

    // R6: longer intervals
    step(1'b1, 8'hA5, 2'd1, 1'b1, 1'b1, "R2");
    ticks(4100, 2'd1, "R6");
    step(1'b1, 8'hA5, 2'd3, 1'b1, 1'b1, "R2");
    ticks(65540, 2'd3, "R6");

    // random mix on the shortest interval
    for (int i = 0; i < 20000; i++) begin
      int r = $urandom_range(0, 99);
      bit we = 1'b0;
      logic [7:0] d = 8'($urandom);
      if (r < 25) begin we = 1'b1; d = m_armed ? ~m_key : d; end
      else if (r < 35) begin we = 1'b1; d = m_armed ? m_key : d; end
      else if (r < 37) we = 1'b1;
      step(we, d, 2'd0, $urandom_range(0, 9) < 8, $urandom_range(0, 499) != 0, "R12");
    end

    step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1, "R10");
    step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1, "R10");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule